// File: doc/BRIEF.md
# Address Translation Route Selector

This block sits at the front of an address translation path. For every virtual address presented with a request strobe, it decides how the address is translated. There are four possible routes. The address can be passed straight through in direct mode. It can be translated by one of four direct-map windows. It can be rejected because its upper bits are not a proper sign extension. Otherwise it is handed on to a page-table lookup structure, which lies outside this block.

The inputs are:
- two mode bits: a direct-addressing enable and a paging enable;
- a privilege flag: kernel or user;
- a flag that selects 32-bit or 64-bit addressing;
- four window configuration words.

For the two direct routes, the block also produces the physical address and a read/write/execute permission triple. All results appear together, registered, one clock after the request.

Top module: `addr_route_sel`

## Requirements
- R1: When direct_en_i=1 and paging_en_i=0, the route is DIRECT (code 0). pa_o is va_i[PA_BITS-1:0] and perm_o is 3'b111. The window configuration has no effect in this case.
- R2: Window i hits when both of the following hold:
  - Its enable bit for the current privilege is set. Bit 0 applies to kernel (user_mode_i=0) and bit 3 to user (user_mode_i=1).
  - Its segment field matches the address. In 64-bit mode, cfg[63:60] must equal va_i[63:60]. In 32-bit mode, cfg[31:29] must equal va_i[31:29].
- R3: When more than one window hits, the lowest-numbered window wins. The route is WINDOW (code 1) and win_idx_o gives the index of the winning window.
- R4: In 64-bit mode, a window hit gives pa_o = va_i[VA_BITS-1:0], zero-extended or truncated to PA_BITS.
- R5: In 32-bit mode, a window hit gives pa_o = {cfg[27:25], va_i[28:0]}, zero-extended to PA_BITS.
- R6: A window hit gives perm_o = 3'b111 (bit 2 read, bit 1 write, bit 0 execute).
- R7: If neither the direct route nor any window applies, the block checks va_i[VA_BITS+15:VA_BITS]. If those bits are neither all zeros nor all ones, the route is BADADDR (code 2), with pa_o=0 and perm_o=0.
- R8: An address that reaches the check in R7 and passes it is routed MAPPED (code 3), with pa_o=0 and perm_o=0.
- R9: Timing and reset:
  - rsp_valid_o equals req_valid_i delayed by one clock.
  - The results of a request appear on the clock edge that samples it.
  - Synchronous reset clears every output to zero.
- R10: win_idx_o is 0 whenever the route is not WINDOW.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid_i | input | 1 | Request strobe |
| va_i | input | XLEN | Virtual address |
| direct_en_i | input | 1 | Direct-addressing enable |
| paging_en_i | input | 1 | Paging enable |
| user_mode_i | input | 1 | 1 = user privilege, 0 = kernel |
| mode64_i | input | 1 | 1 = 64-bit addressing, 0 = 32-bit |
| win_cfg_i | input | NWIN*XLEN | Window configuration words, window 0 in the low bits |
| rsp_valid_o | output | 1 | Result valid |
| route_o | output | 2 | 0 DIRECT, 1 WINDOW, 2 BADADDR, 3 MAPPED |
| win_idx_o | output | IDX_W | Index of the window that hit |
| pa_o | output | PA_BITS | Physical address for the direct routes |
| perm_o | output | 3 | Read/write/execute grant |

## Verification
Some properties are checked by assertions on every cycle:
- the one-cycle strobe delay;
- direct-mode precedence and its pass-through address;
- the full grant on both direct routes;
- zero address and zero grant on the fault and mapped routes;
- a zero window index off the window route;
- the address arithmetic for window hits in both 64-bit and 32-bit mode.

Only the bench scenarios can show that the right window was chosen. This covers the privilege-specific enable bits, lowest-index priority among overlapping windows, and the boundary between the canonical and non-canonical upper bits. These results depend on comparing the design against an independent reference model.

// File: rtl/ars_pkg.sv
package ars_pkg;

  typedef enum logic [1:0] {
    ROUTE_DIRECT  = 2'd0,
    ROUTE_WINDOW  = 2'd1,
    ROUTE_BADADDR = 2'd2,
    ROUTE_MAPPED  = 2'd3
  } route_e;

  // Window configuration word layout
  localparam int WEN_KERN_BIT = 0;
  localparam int WEN_USER_BIT = 3;
  localparam int SEG32_LSB    = 29;
  localparam int SEG32_W      = 3;
  localparam int PSEG32_LSB   = 25;
  localparam int SEG64_W      = 4;

  localparam logic [2:0] PERM_ALL  = 3'b111;
  localparam logic [2:0] PERM_NONE = 3'b000;

endpackage

// File: rtl/ars_win_match.sv
module ars_win_match #(
  parameter int XLEN    = 64,
  parameter int VA_BITS = 48,
  parameter int PA_BITS = 48
) (
  input  logic [XLEN-1:0]    cfg_i,
  input  logic [XLEN-1:0]    va_i,
  input  logic               user_i,
  input  logic               mode64_i,
  output logic               hit_o,
  output logic [PA_BITS-1:0] pa_o
);
  import ars_pkg::*;

  localparam int SEG64_LSB = XLEN - SEG64_W;
  localparam logic [XLEN-1:0] VA_MASK = {{(XLEN-VA_BITS){1'b0}}, {VA_BITS{1'b1}}};

  logic             en;
  logic             seg_eq;
  logic [XLEN-1:0]  pa64;
  logic [XLEN-1:0]  pa32;

  always_comb begin
    en = user_i ? cfg_i[WEN_USER_BIT] : cfg_i[WEN_KERN_BIT];
    if (mode64_i)
      seg_eq = (cfg_i[XLEN-1:SEG64_LSB] == va_i[XLEN-1:SEG64_LSB]);
    else
      seg_eq = (cfg_i[SEG32_LSB +: SEG32_W] == va_i[SEG32_LSB +: SEG32_W]);
    hit_o = en & seg_eq;
    pa64  = va_i & VA_MASK;
    pa32  = XLEN'({cfg_i[PSEG32_LSB +: SEG32_W], va_i[SEG32_LSB-1:0]});
    pa_o  = mode64_i ? pa64[PA_BITS-1:0] : pa32[PA_BITS-1:0];
  end

endmodule

// File: rtl/ars_prio.sv
module ars_prio #(
  parameter int N       = 4,
  parameter int PA_BITS = 48,
  localparam int IDX_W  = (N > 1) ? $clog2(N) : 1
) (
  input  logic [N-1:0]         hit_i,
  input  logic [N*PA_BITS-1:0] pa_i,
  output logic                 any_o,
  output logic [IDX_W-1:0]     idx_o,
  output logic [PA_BITS-1:0]   pa_o
);

  always_comb begin
    any_o = 1'b0;
    idx_o = '0;
    pa_o  = '0;
    for (int i = N - 1; i >= 0; i--) begin
      if (hit_i[i]) begin
        any_o = 1'b1;
        idx_o = IDX_W'(i);
        pa_o  = pa_i[i*PA_BITS +: PA_BITS];
      end
    end
  end

endmodule

// File: rtl/ars_canon.sv
module ars_canon #(
  parameter int XLEN    = 64,
  parameter int VA_BITS = 48,
  parameter int CHK_W   = 16
) (
  input  logic [XLEN-1:0] va_i,
  output logic            ok_o
);
  logic [CHK_W-1:0] hi;

  always_comb begin
    hi   = va_i[VA_BITS +: CHK_W];
    ok_o = (&hi) | ~(|hi);
  end

endmodule

// File: rtl/addr_route_sel.sv
module addr_route_sel #(
  parameter int XLEN    = 64,
  parameter int VA_BITS = 48,
  parameter int PA_BITS = 48,
  parameter int NWIN    = 4,
  parameter int CHK_W   = 16,
  localparam int IDX_W  = (NWIN > 1) ? $clog2(NWIN) : 1
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 req_valid_i,
  input  logic [XLEN-1:0]      va_i,
  input  logic                 direct_en_i,
  input  logic                 paging_en_i,
  input  logic                 user_mode_i,
  input  logic                 mode64_i,
  input  logic [NWIN*XLEN-1:0] win_cfg_i,
  output logic                 rsp_valid_o,
  output logic [1:0]           route_o,
  output logic [IDX_W-1:0]     win_idx_o,
  output logic [PA_BITS-1:0]   pa_o,
  output logic [2:0]           perm_o
);
  import ars_pkg::*;

  logic [NWIN-1:0]         hit;
  logic [NWIN*PA_BITS-1:0] win_pa;
  logic                    any_hit;
  logic [IDX_W-1:0]        hit_idx;
  logic [PA_BITS-1:0]      hit_pa;
  logic                    canon_ok;

  for (genvar g = 0; g < NWIN; g++) begin : g_win
    ars_win_match #(
      .XLEN(XLEN), .VA_BITS(VA_BITS), .PA_BITS(PA_BITS)
    ) u_match (
      .cfg_i   (win_cfg_i[g*XLEN +: XLEN]),
      .va_i    (va_i),
      .user_i  (user_mode_i),
      .mode64_i(mode64_i),
      .hit_o   (hit[g]),
      .pa_o    (win_pa[g*PA_BITS +: PA_BITS])
    );
  end

  ars_prio #(.N(NWIN), .PA_BITS(PA_BITS)) u_prio (
    .hit_i(hit),
    .pa_i (win_pa),
    .any_o(any_hit),
    .idx_o(hit_idx),
    .pa_o (hit_pa)
  );

  ars_canon #(.XLEN(XLEN), .VA_BITS(VA_BITS), .CHK_W(CHK_W)) u_canon (
    .va_i(va_i),
    .ok_o(canon_ok)
  );

  route_e             nx_route;
  logic [IDX_W-1:0]   nx_idx;
  logic [PA_BITS-1:0] nx_pa;
  logic [2:0]         nx_perm;

  always_comb begin
    nx_route = ROUTE_MAPPED;
    nx_idx   = '0;
    nx_pa    = '0;
    nx_perm  = PERM_NONE;
    if (direct_en_i && !paging_en_i) begin
      nx_route = ROUTE_DIRECT;
      nx_pa    = va_i[PA_BITS-1:0];
      nx_perm  = PERM_ALL;
    end else if (any_hit) begin
      nx_route = ROUTE_WINDOW;
      nx_idx   = hit_idx;
      nx_pa    = hit_pa;
      nx_perm  = PERM_ALL;
    end else if (!canon_ok) begin
      nx_route = ROUTE_BADADDR;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rsp_valid_o <= 1'b0;
      route_o     <= '0;
      win_idx_o   <= '0;
      pa_o        <= '0;
      perm_o      <= '0;
    end else begin
      rsp_valid_o <= req_valid_i;
      if (req_valid_i) begin
        route_o   <= nx_route;
        win_idx_o <= nx_idx;
        pa_o      <= nx_pa;
        perm_o    <= nx_perm;
      end
    end
  end

endmodule

// File: rtl/ars_checker.sv
module ars_checker #(
  parameter int XLEN    = 64,
  parameter int VA_BITS = 48,
  parameter int PA_BITS = 48,
  parameter int NWIN    = 4,
  parameter int IDX_W   = 2
) (
  input logic                 clk,
  input logic                 rst,
  input logic                 req_valid_i,
  input logic [XLEN-1:0]      va_i,
  input logic                 direct_en_i,
  input logic                 paging_en_i,
  input logic                 mode64_i,
  input logic                 rsp_valid_o,
  input logic [1:0]           route_o,
  input logic [IDX_W-1:0]     win_idx_o,
  input logic [PA_BITS-1:0]   pa_o,
  input logic [2:0]           perm_o
);
  import ars_pkg::*;

  localparam logic [XLEN-1:0] VMASK = {{(XLEN-VA_BITS){1'b0}}, {VA_BITS{1'b1}}};
  localparam logic [XLEN-1:0] LOW32 = XLEN'((64'd1 << SEG32_LSB) - 64'd1);

  AST_VALID_RISE: assert property (@(posedge clk) disable iff (rst)
    req_valid_i |=> rsp_valid_o); // R9
  AST_VALID_IDLE: assert property (@(posedge clk) disable iff (rst)
    !req_valid_i |=> !rsp_valid_o); // R9
  AST_DIRECT_WINS: assert property (@(posedge clk) disable iff (rst)
    (req_valid_i && direct_en_i && !paging_en_i) |=>
      (route_o == ROUTE_DIRECT && pa_o == PA_BITS'($past(va_i)))); // R1
  AST_FULL_GRANT: assert property (@(posedge clk) disable iff (rst)
    (rsp_valid_o && (route_o == ROUTE_DIRECT || route_o == ROUTE_WINDOW)) |->
      perm_o == PERM_ALL); // R6
  AST_FAULT_EMPTY: assert property (@(posedge clk) disable iff (rst)
    (rsp_valid_o && route_o == ROUTE_BADADDR) |-> (perm_o == '0 && pa_o == '0)); // R7
  AST_MAPPED_EMPTY: assert property (@(posedge clk) disable iff (rst)
    (rsp_valid_o && route_o == ROUTE_MAPPED) |-> (perm_o == '0 && pa_o == '0)); // R8
  AST_IDX_ZERO: assert property (@(posedge clk) disable iff (rst)
    (rsp_valid_o && route_o != ROUTE_WINDOW) |-> win_idx_o == '0); // R10
  AST_WIN64_PA: assert property (@(posedge clk) disable iff (rst)
    (req_valid_i && mode64_i) |=>
      (route_o != ROUTE_WINDOW || pa_o == PA_BITS'($past(va_i) & VMASK))); // R4
  AST_WIN32_PA_LOW: assert property (@(posedge clk) disable iff (rst)
    (req_valid_i && !mode64_i) |=>
      (route_o != ROUTE_WINDOW ||
       (XLEN'(pa_o) & LOW32) == ($past(va_i) & LOW32))); // R5

endmodule

bind addr_route_sel ars_checker #(
  .XLEN(XLEN), .VA_BITS(VA_BITS), .PA_BITS(PA_BITS), .NWIN(NWIN), .IDX_W(IDX_W)
) u_ars_chk (
  .clk(clk), .rst(rst), .req_valid_i(req_valid_i), .va_i(va_i),
  .direct_en_i(direct_en_i), .paging_en_i(paging_en_i), .mode64_i(mode64_i),
  .rsp_valid_o(rsp_valid_o), .route_o(route_o), .win_idx_o(win_idx_o),
  .pa_o(pa_o), .perm_o(perm_o)
);

// File: tb/sim_addr_route_sel.sv
module sim_addr_route_sel;

  logic         clk = 1'b0;
  logic         rst = 1'b1;
  logic         req_valid = 1'b0;
  logic [63:0]  va = '0;
  logic         da = 1'b0, pg = 1'b0, user = 1'b0, m64 = 1'b1;
  logic [63:0]  wc [4];
  logic [255:0] wflat;
  logic         rsp_valid;
  logic [1:0]   route;
  logic [1:0]   widx;
  logic [47:0]  pa;
  logic [2:0]   perm;

  int n_chk = 0;
  int n_fail = 0;
  bit done = 1'b0;

  always #4 clk = ~clk;

  assign wflat = {wc[3], wc[2], wc[1], wc[0]};

  addr_route_sel u0 (
    .clk(clk), .rst(rst), .req_valid_i(req_valid), .va_i(va),
    .direct_en_i(da), .paging_en_i(pg), .user_mode_i(user), .mode64_i(m64),
    .win_cfg_i(wflat), .rsp_valid_o(rsp_valid), .route_o(route),
    .win_idx_o(widx), .pa_o(pa), .perm_o(perm)
  );

  task automatic chk(input string tag, input string what,
                     input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s actual=%h expected=%h", tag, what, act, exp);
    end
  endtask

  function automatic void model(output logic [1:0] r, output logic [1:0] ix,
                                output logic [47:0] p, output logic [2:0] pm);
    logic [15:0] hi;
    r = 2'd3; ix = 2'd0; p = '0; pm = 3'b000;
    if (da && !pg) begin
      r = 2'd0; p = va[47:0]; pm = 3'b111;
      return;
    end
    for (int i = 0; i < 4; i++) begin
      logic en, mt;
      en = user ? wc[i][3] : wc[i][0];
      mt = m64 ? (wc[i][63:60] == va[63:60]) : (wc[i][31:29] == va[31:29]);
      if (en && mt) begin
        r = 2'd1; ix = 2'(i); pm = 3'b111;
        p = m64 ? va[47:0] : {16'h0, wc[i][27:25], va[28:0]};
        return;
      end
    end
    hi = va[63:48];
    if (hi != 16'h0 && hi != 16'hFFFF) r = 2'd2;
  endfunction

  // Apply one request at a negedge, check at the next negedge
  task automatic req(input string note);
    logic [1:0] er, ei;
    logic [47:0] ep;
    logic [2:0] epm;
    string tp, tr, ti;
    model(er, ei, ep, epm);
    req_valid = 1'b1;
    @(negedge clk);
    case (er)
      2'd0: begin tr = "R1"; tp = "R1"; end
      2'd1: begin tr = "R3"; tp = m64 ? "R4" : "R5"; end
      2'd2: begin tr = "R7"; tp = "R7"; end
      default: begin tr = "R8"; tp = "R8"; end
    endcase
    ti = (er == 2'd1) ? "R3" : "R10";
    chk(tr, {"route ", note}, 64'(route), 64'(er));
    chk(tp, {"pa ", note}, 64'(pa), 64'(ep));
    chk((er == 2'd1) ? "R6" : tr, {"perm ", note}, 64'(perm), 64'(epm));
    chk(ti, {"idx ", note}, 64'(widx), 64'(ei));
    chk("R9", {"valid ", note}, 64'(rsp_valid), 64'd1);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_fail++;
      $display("FAIL R9 watchdog expired actual=%0d expected=%0d", 0, 1);
      $display("[TB] %0d tests run, %0d failed", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    int seed;
    seed = 1234;
    void'($urandom(seed));
    for (int i = 0; i < 4; i++) wc[i] = '0;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R9 reset state
    chk("R9", "reset valid", 64'(rsp_valid), 64'd0);
    chk("R9", "reset route", 64'(route), 64'd0);
    chk("R9", "reset pa", 64'(pa), 64'd0);
    chk("R9", "reset perm", 64'(perm), 64'd0);

    // R1: direct mode overrides a window that would hit
    wc[0] = 64'hA000_0000_0000_0009;
    va = 64'hA123_4567_89AB_CDEF; da = 1; pg = 0; user = 0; m64 = 1;
    req("R1 direct over window");
    // R2/R4: same setup with paging on, kernel bit set -> window 0
    pg = 1; req("R2 kernel window hit");
    // R2: user level, only kernel enable set -> no hit; non-canonical -> R7
    wc[0] = 64'hA000_0000_0000_0001; user = 1;
    req("R2 user bit clear");
    // R2: user enable only, kernel request misses
    wc[0] = 64'hA000_0000_0000_0008; user = 0;
    req("R2 kernel bit clear");
    user = 1; req("R2 user bit set");
    // R3: windows 1 and 2 both hit, 1 wins
    wc[0] = 64'h5000_0000_0000_0009;
    wc[1] = 64'hA000_0000_0000_0001;
    wc[2] = 64'hA000_0000_0000_0001;
    user = 0; req("R3 priority");
    // R5: 32-bit window with physical segment
    for (int i = 0; i < 4; i++) wc[i] = '0;
    wc[3] = 64'h0000_0000_AE00_0001;
    m64 = 0; va = 64'h0000_0000_B234_5678; req("R5 32-bit window");
    // R7: non-canonical with no window
    for (int i = 0; i < 4; i++) wc[i] = '0;
    m64 = 1; va = 64'h0001_0000_0000_0000; req("R7 bad address");
    // R8: canonical negative
    va = 64'hFFFF_8000_1234_0000; req("R8 canonical high");
    va = 64'h0000_7FFF_FFFF_F000; req("R8 canonical low");

    // R9: strobe low gives rsp_valid low
    req_valid = 1'b0;
    @(negedge clk);
    chk("R9", "valid idle", 64'(rsp_valid), 64'd0);

    // Random mix
    for (int n = 0; n < 400; n++) begin
      int sel;
      va = {$urandom, $urandom};
      sel = $urandom % 4;
      if (sel == 0) va[63:48] = 16'h0;
      else if (sel == 1) va[63:48] = 16'hFFFF;
      da = ($urandom % 4) == 0;
      pg = $urandom % 2;
      user = $urandom % 2;
      m64 = $urandom % 2;
      if (!m64 && ($urandom % 2)) va[63:32] = '0;
      for (int i = 0; i < 4; i++) begin
        wc[i] = {$urandom, $urandom};
        if ($urandom % 2) wc[i][63:60] = va[63:60];
        if ($urandom % 2) wc[i][31:29] = va[31:29];
      end
      req("random");
    end

    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", n_chk, n_fail);
    $finish;
  end

endmodule